// File: doc/BRIEF.md
# USB Low-Speed Token and Handshake Decider

This block sits behind the bit-level receiver of a low-speed USB device. It sees the packet as a stream of already decoded bytes, one per valid strobe, closed by an end-of-packet strobe. It classifies the packet identifier of each packet. For token packets it checks the field layout, the CRC5 and the device address. It remembers which of its own SETUP or OUT tokens opened the current transaction. When the following DATA0 or DATA1 packet ends, it tells the transmitter which handshake to send.

The receive side reports through `buf_busy` whether the previously accepted payload is still waiting to be consumed. A data packet that arrives while the buffer is busy is refused with NAK, and the host then repeats the whole transaction. Packets for another device, packets with a corrupted identifier or CRC5, and data packets with no transaction open to them produce no reply at all. This lets a hub repeat all traffic to every device. The device address is held in the block and loaded through its own write port.

Top module: `usb_token_decoder`

## Requirements
- R1: A first byte whose high nibble is not the bitwise inverse of its low nibble is a corrupted packet. It produces no output pulse and closes any open transaction, so the next data packet gets no reply.
- R2: The identifier is the low nibble of the first byte. 0x1 is OUT (byte 0xE1), 0x9 is IN (0x69) and 0xD is SETUP (0x2D); these are the tokens. 0x3 is DATA0 (0xC3) and 0xB is DATA1 (0x4B); both are data packets. An own IN token is reported but does not open a transaction.
- R3: A token is exactly three bytes. The 16 bits after the identifier, first byte in bits 7..0, hold the address in bits 6..0, the endpoint in bits 10..7 and the CRC5 in bits 15..11. An accepted token raises `tok_valid` with the endpoint on `tok_ep`.
- R4: The CRC5 is computed over bits 10..0, least significant first. The generator is x^5+x^2+1 and the register starts at all ones. The field holds the inverted register, with its top register bit in field bit 0. A token with a mismatching CRC5 is ignored and closes any open transaction.
- R5: A token whose address differs from the device address is ignored and closes any open transaction.
- R6: The device address is 0 after reset and takes `dev_addr_wdata` on the edge where `dev_addr_we` is high. A token that ends in the same cycle as a write is compared with the address held before that write.
- R7: A DATA0 or DATA1 packet that ends while an own SETUP or OUT transaction is open, with `buf_busy` low, gets an ACK. It also raises `data_take` with `data_tok` set to the opening token's identifier nibble. Reply codes are 0 none, 1 ACK, 2 NAK, 3 STALL, and this block issues only 1 and 2.
- R8: The same data packet with `buf_busy` high gets NAK and no `data_take`. The transaction is closed either way.
- R9: A data packet with no open transaction gets no reply. Any other packet (a second data packet, an IN token, a start-of-frame or handshake identifier) also closes the transaction.
- R10: All outputs are single-cycle pulses, registered in the cycle after `rx_eop` is sampled. A byte strobed in the same cycle as `rx_eop` is the last byte of the packet. After reset all outputs are 0.
- R11: A token of any length other than three bytes is corrupted and closes the transaction. An end-of-packet with no bytes at all has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A decoded byte is on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of the current packet |
| dev_addr_we | input | 1 | Load the device address |
| dev_addr_wdata | input | 7 | New device address |
| buf_busy | input | 1 | Previous payload not yet consumed |
| reply_valid | output | 1 | A handshake must be sent |
| reply_code | output | 2 | Handshake code: 0 none, 1 ACK, 2 NAK, 3 STALL |
| data_take | output | 1 | Payload of the ended data packet is accepted |
| data_tok | output | 4 | Identifier nibble of the token the payload belongs to |
| tok_valid | output | 1 | An own, intact token ended |
| tok_ep | output | 4 | Endpoint of that token |

## Verification
Two events can meet in a single cycle. An address write can coincide with the end of a token. The last data byte can also be strobed together with the end-of-packet. The bench writes a new address exactly in the end-of-packet cycle of an OUT token aimed at the old address, and expects the token to be accepted. It then expects only the new address to match afterwards. It also closes a DATA1 packet with its last byte and the end strobe together, and expects the normal ACK one cycle later.

// File: rtl/usbtk_pkg.sv
`timescale 1ns/1ps
package usbtk_pkg;

    localparam int BYTE_W  = 8;
    localparam int PID_W   = 4;
    localparam int ADDR_W  = 7;
    localparam int EP_W    = 4;
    localparam int CRC_W   = 5;
    localparam int FIELD_W = ADDR_W + EP_W;
    localparam int BODY_W  = FIELD_W + CRC_W;
    localparam int BODY_BYTES = BODY_W / BYTE_W;

    localparam logic [PID_W-1:0] PID_OUT   = 4'h1;
    localparam logic [PID_W-1:0] PID_IN    = 4'h9;
    localparam logic [PID_W-1:0] PID_SETUP = 4'hD;
    localparam logic [PID_W-1:0] PID_DATA0 = 4'h3;
    localparam logic [PID_W-1:0] PID_DATA1 = 4'hB;

    localparam logic [CRC_W-1:0] CRC5_POLY = 5'b00101;
    localparam logic [CRC_W-1:0] CRC5_SEED = 5'b11111;

    typedef enum logic [1:0] {
        REPLY_NONE  = 2'd0,
        REPLY_ACK   = 2'd1,
        REPLY_NAK   = 2'd2,
        REPLY_STALL = 2'd3
    } reply_e;

    typedef struct packed {
        logic             ok;
        logic             is_token;
        logic             is_data;
        logic             opens_rx;
        logic [PID_W-1:0] nib;
    } pid_info_t;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [EP_W-1:0]   ep;
        logic [ADDR_W-1:0] addr;
    } tok_word_t;

    // CRC5 field value for an 11-bit address/endpoint word sent LSB first.
    function automatic logic [CRC_W-1:0] crc5_field(input logic [FIELD_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic [CRC_W-1:0] f;
        logic             fb;
        r = CRC5_SEED;
        for (int i = 0; i < FIELD_W; i++) begin
            fb = d[i] ^ r[CRC_W-1];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC5_POLY : '0);
        end
        for (int k = 0; k < CRC_W; k++) begin
            f[k] = ~r[CRC_W-1-k];
        end
        return f;
    endfunction

endpackage

// File: rtl/usbtk_pkt_collect.sv
`timescale 1ns/1ps
module usbtk_pkt_collect
    import usbtk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_valid,
    input  logic [BYTE_W-1:0]        rx_data,
    input  logic                     rx_eop,
    output logic                     fin,
    output logic [CNT_W-1:0]         fin_len,
    output logic [BYTE_W-1:0]        fin_pid,
    output logic [BODY_W-1:0]        fin_body
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0]  cnt_q,  cnt_n;
    logic [BYTE_W-1:0] pid_q,  pid_n;
    logic [BODY_W-1:0] body_q, body_n;

    // Next-state view: a byte strobed together with the end is included.
    always_comb begin
        cnt_n  = cnt_q;
        pid_n  = pid_q;
        body_n = body_q;
        if (rx_valid) begin
            if (cnt_q == '0) begin
                pid_n = rx_data;
            end
            for (int i = 0; i < BODY_BYTES; i++) begin
                if (cnt_q == CNT_W'(i + 1)) begin
                    body_n[BYTE_W*i +: BYTE_W] = rx_data;
                end
            end
            if (cnt_q != CNT_MAX) begin
                cnt_n = cnt_q + 1'b1;
            end
        end
    end

    assign fin      = rx_eop;
    assign fin_len  = cnt_n;
    assign fin_pid  = pid_n;
    assign fin_body = body_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            pid_q  <= '0;
            body_q <= '0;
        end else begin
            cnt_q  <= rx_eop ? '0 : cnt_n;
            pid_q  <= pid_n;
            body_q <= body_n;
        end
    end

    // R10: every packet end restarts byte counting for the next packet
    assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (rst)
        rx_eop |=> (cnt_q == '0));

    // R11: the count saturates instead of wrapping back to an empty packet
    assert_cnt_saturate_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !rx_eop) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/usbtk_pid_class.sv
`timescale 1ns/1ps
module usbtk_pid_class
    import usbtk_pkg::*;
(
    input  logic [BYTE_W-1:0] pid_byte,
    output pid_info_t         info
);
    logic [PID_W-1:0] nib;
    logic             chk_ok;

    assign nib    = pid_byte[PID_W-1:0];
    assign chk_ok = (pid_byte[BYTE_W-1:PID_W] == ~nib);

    always_comb begin
        info          = '0;
        info.nib      = nib;
        info.ok       = chk_ok;
        info.is_token = chk_ok && (nib == PID_OUT || nib == PID_IN || nib == PID_SETUP);
        info.is_data  = chk_ok && (nib == PID_DATA0 || nib == PID_DATA1);
        info.opens_rx = chk_ok && (nib == PID_OUT || nib == PID_SETUP);
    end

endmodule

// File: rtl/usbtk_token_check.sv
`timescale 1ns/1ps
module usbtk_token_check
    import usbtk_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int TOK_LEN = 3
) (
    input  logic [BODY_W-1:0] body,
    input  logic [CNT_W-1:0]  len,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              shape_ok,
    output logic              crc_ok,
    output logic              addr_hit,
    output logic [EP_W-1:0]   ep
);
    tok_word_t w;

    assign w        = tok_word_t'(body);
    assign shape_ok = (len == CNT_W'(TOK_LEN));
    assign crc_ok   = (crc5_field({w.ep, w.addr}) == w.crc);
    assign addr_hit = (w.addr == dev_addr);
    assign ep       = w.ep;

endmodule

// File: rtl/usbtk_reply_sel.sv
`timescale 1ns/1ps
module usbtk_reply_sel
    import usbtk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin,
    input  logic [CNT_W-1:0] fin_len,
    input  pid_info_t        info,
    input  logic             shape_ok,
    input  logic             crc_ok,
    input  logic             addr_hit,
    input  logic [EP_W-1:0]  ep,
    input  logic             buf_busy,
    output logic             reply_valid,
    output reply_e           reply_code,
    output logic             data_take,
    output logic [PID_W-1:0] data_tok,
    output logic             tok_valid,
    output logic [EP_W-1:0]  tok_ep
);
    logic [PID_W-1:0] held_q;   // opening token nibble, 0 = no transaction
    logic             pkt_end;
    logic             own_tok;
    logic             data_hit;

    assign pkt_end  = fin && (fin_len != '0);
    assign own_tok  = pkt_end && info.is_token && shape_ok && crc_ok && addr_hit;
    assign data_hit = pkt_end && info.is_data && (held_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= '0;
            reply_valid <= 1'b0;
            reply_code  <= REPLY_NONE;
            data_take   <= 1'b0;
            data_tok    <= '0;
            tok_valid   <= 1'b0;
            tok_ep      <= '0;
        end else begin
            reply_valid <= 1'b0;
            reply_code  <= REPLY_NONE;
            data_take   <= 1'b0;
            data_tok    <= '0;
            tok_valid   <= 1'b0;
            tok_ep      <= '0;
            if (pkt_end) begin
                held_q <= '0;
                if (own_tok) begin
                    tok_valid <= 1'b1;
                    tok_ep    <= ep;
                    if (info.opens_rx) begin
                        held_q <= info.nib;
                    end
                end else if (data_hit) begin
                    reply_valid <= 1'b1;
                    if (buf_busy) begin
                        reply_code <= REPLY_NAK;
                    end else begin
                        reply_code <= REPLY_ACK;
                        data_take  <= 1'b1;
                        data_tok   <= held_q;
                    end
                end
            end
        end
    end

    // R7: ACK only when the buffer was free at the end of the data packet
    assert_ack_free_R7: assert property (@(posedge clk) disable iff (rst)
        (reply_valid && reply_code == REPLY_ACK) |-> !$past(buf_busy));

    // R8: NAK only when the buffer was busy at the end of the data packet
    assert_nak_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (reply_valid && reply_code == REPLY_NAK) |-> $past(buf_busy));

    // R7: accepting a payload always goes with an ACK, never a STALL
    assert_take_ack_R7: assert property (@(posedge clk) disable iff (rst)
        data_take |-> (reply_valid && reply_code == REPLY_ACK));

    // R9: a handshake needs a transaction that was open before it
    assert_reply_open_R9: assert property (@(posedge clk) disable iff (rst)
        reply_valid |-> ($past(held_q) != '0));

    // R10: a handshake request lasts one cycle
    assert_reply_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        reply_valid |=> !reply_valid);

endmodule

// File: rtl/usb_token_decoder.sv
`timescale 1ns/1ps
module usb_token_decoder
    import usbtk_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int TOK_LEN = 1 + BODY_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    input  logic              dev_addr_we,
    input  logic [6:0]        dev_addr_wdata,
    input  logic              buf_busy,
    output logic              reply_valid,
    output logic [1:0]        reply_code,
    output logic              data_take,
    output logic [3:0]        data_tok,
    output logic              tok_valid,
    output logic [3:0]        tok_ep
);
    logic [ADDR_W-1:0] dev_addr_q;
    logic              fin;
    logic [CNT_W-1:0]  fin_len;
    logic [BYTE_W-1:0] fin_pid;
    logic [BODY_W-1:0] fin_body;
    pid_info_t         info;
    logic              shape_ok, crc_ok, addr_hit;
    logic [EP_W-1:0]   ep;
    reply_e            code;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_addr_q <= '0;
        end else if (dev_addr_we) begin
            dev_addr_q <= dev_addr_wdata;
        end
    end

    usbtk_pkt_collect #(.CNT_W(CNT_W)) collect_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .fin(fin), .fin_len(fin_len), .fin_pid(fin_pid),
        .fin_body(fin_body)
    );

    usbtk_pid_class class_i (
        .pid_byte(fin_pid), .info(info)
    );

    usbtk_token_check #(.CNT_W(CNT_W), .TOK_LEN(TOK_LEN)) check_i (
        .body(fin_body), .len(fin_len), .dev_addr(dev_addr_q),
        .shape_ok(shape_ok), .crc_ok(crc_ok), .addr_hit(addr_hit), .ep(ep)
    );

    usbtk_reply_sel #(.CNT_W(CNT_W)) reply_i (
        .clk(clk), .rst(rst), .fin(fin), .fin_len(fin_len), .info(info),
        .shape_ok(shape_ok), .crc_ok(crc_ok), .addr_hit(addr_hit), .ep(ep),
        .buf_busy(buf_busy), .reply_valid(reply_valid), .reply_code(code),
        .data_take(data_take), .data_tok(data_tok), .tok_valid(tok_valid),
        .tok_ep(tok_ep)
    );

    assign reply_code = code;

    // R6: a write lands in the address register on the next edge
    assert_addr_load_R6: assert property (@(posedge clk) disable iff (rst)
        dev_addr_we |=> (dev_addr_q == $past(dev_addr_wdata)));

    // R10: handshake requests follow a packet end by exactly one cycle
    assert_reply_after_eop_R10: assert property (@(posedge clk) disable iff (rst)
        reply_valid |-> $past(rx_eop));

    // R3: token reports follow a packet end by exactly one cycle
    assert_tok_after_eop_R3: assert property (@(posedge clk) disable iff (rst)
        tok_valid |-> $past(rx_eop));

endmodule

// File: tb/usb_token_decoder_tb_top.sv
`timescale 1ns/1ps
module usb_token_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_eop = 1'b0;
    logic       dev_addr_we = 1'b0;
    logic [6:0] dev_addr_wdata = 7'h00;
    logic       buf_busy = 1'b0;
    logic       reply_valid;
    logic [1:0] reply_code;
    logic       data_take;
    logic [3:0] data_tok;
    logic       tok_valid;
    logic [3:0] tok_ep;

    int errs   = 0;
    int checks = 0;
    bit due    = 1'b0;
    bit done   = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    usb_token_decoder dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .dev_addr_we(dev_addr_we),
        .dev_addr_wdata(dev_addr_wdata), .buf_busy(buf_busy),
        .reply_valid(reply_valid), .reply_code(reply_code),
        .data_take(data_take), .data_tok(data_tok),
        .tok_valid(tok_valid), .tok_ep(tok_ep)
    );

    function automatic logic [12:0] got_vec();
        return {reply_valid, reply_code, data_take, data_tok, tok_valid, tok_ep};
    endfunction

    function automatic logic [12:0] e_none();
        return 13'd0;
    endfunction
    function automatic logic [12:0] e_tok(input logic [3:0] ep);
        return {1'b0, 2'd0, 1'b0, 4'h0, 1'b1, ep};
    endfunction
    function automatic logic [12:0] e_ack(input logic [3:0] t);
        return {1'b1, 2'd1, 1'b1, t, 1'b0, 4'h0};
    endfunction
    function automatic logic [12:0] e_nak();
        return {1'b1, 2'd2, 1'b0, 4'h0, 1'b0, 4'h0};
    endfunction

    // Independent CRC5 model per R4
    function automatic logic [4:0] bench_crc5(input logic [10:0] d);
        logic [4:0] r = 5'h1F;
        logic [4:0] out;
        for (int i = 0; i < 11; i++) begin
            logic fb;
            fb = d[i] ^ r[4];
            r  = {r[3:0], 1'b0};
            if (fb) r = r ^ 5'b00101;
        end
        for (int k = 0; k < 5; k++) out[k] = !r[4-k];
        return out;
    endfunction

    // Scoreboard monitor
    always @(posedge clk) due <= rx_eop && !rst;

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (due) begin
                logic [12:0] ev;
                string       t;
                checks++;
                if (exp_q.size() == 0) begin
                    errs++;
                    $display("FAIL %s: actual=%h expected=<none queued>", "R10", got_vec());
                end else begin
                    ev = exp_q.pop_front();
                    t  = tag_q.pop_front();
                    if (got_vec() !== ev) begin
                        errs++;
                        $display("FAIL %s: actual=%h expected=%h", t, got_vec(), ev);
                    end
                end
            end else if (got_vec() !== 13'd0) begin
                checks++;
                errs++;
                $display("FAIL R10: stray pulse actual=%h expected=%h", got_vec(), 13'd0);
            end
        end
    end

    task automatic send_pkt(input logic [7:0] pk[$], input bit merge,
                            input int wr_at_eop, input logic [12:0] ev,
                            input string tag);
        exp_q.push_back(ev);
        tag_q.push_back(tag);
        for (int i = 0; i < pk.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pk[i];
            rx_eop   = merge && (i == pk.size() - 1);
            if (rx_eop && wr_at_eop >= 0) begin
                dev_addr_we    = 1'b1;
                dev_addr_wdata = 7'(wr_at_eop);
            end
        end
        if (!merge || pk.size() == 0) begin
            @(negedge clk);
            rx_valid = 1'b0;
            rx_eop   = 1'b1;
            if (wr_at_eop >= 0) begin
                dev_addr_we    = 1'b1;
                dev_addr_wdata = 7'(wr_at_eop);
            end
        end
        @(negedge clk);
        rx_valid    = 1'b0;
        rx_eop      = 1'b0;
        dev_addr_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic token(input logic [7:0] pidb, input logic [6:0] a,
                         input logic [3:0] ep, input bit bad_crc, input int wr,
                         input logic [12:0] ev, input string tag);
        logic [7:0]  pk[$];
        logic [15:0] w;
        w = {bench_crc5({ep, a}), ep, a};
        if (bad_crc) w[11] = ~w[11];
        pk.push_back(pidb);
        pk.push_back(w[7:0]);
        pk.push_back(w[15:8]);
        send_pkt(pk, 1'b0, wr, ev, tag);
    endtask

    task automatic data(input logic [7:0] pidb, input bit merge,
                        input logic [12:0] ev, input string tag);
        logic [7:0] pk[$];
        pk.push_back(pidb);
        pk.push_back(8'h80);
        pk.push_back(8'h06);
        send_pkt(pk, merge, -1, ev, tag);
    endtask

    task automatic write_addr(input logic [6:0] a);
        @(negedge clk);
        dev_addr_we    = 1'b1;
        dev_addr_wdata = a;
        @(negedge clk);
        dev_addr_we    = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL R10: watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] pk[$];
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (got_vec() !== 13'd0) begin
            errs++;
            $display("FAIL R10: reset state actual=%h expected=%h", got_vec(), 13'd0);
        end

        // R6 reset address 0, R3 fields, R7 ACK after SETUP
        token(8'h2D, 7'h00, 4'h0, 1'b0, -1, e_tok(4'h0), "R6");
        data(8'hC3, 1'b0, e_ack(4'hD), "R7");
        data(8'hC3, 1'b0, e_none(), "R9");

        // R8 NAK closes the transaction
        write_addr(7'h15);
        token(8'hE1, 7'h15, 4'h2, 1'b0, -1, e_tok(4'h2), "R6");
        buf_busy = 1'b1;
        data(8'h4B, 1'b0, e_nak(), "R8");
        buf_busy = 1'b0;
        data(8'h4B, 1'b0, e_none(), "R8");

        // R10 last byte merged with end strobe, R2 DATA1 accepted after OUT
        token(8'hE1, 7'h15, 4'h2, 1'b0, -1, e_tok(4'h2), "R2");
        data(8'h4B, 1'b1, e_ack(4'h1), "R10");

        // R5 foreign address
        token(8'h2D, 7'h00, 4'h0, 1'b0, -1, e_none(), "R5");
        data(8'hC3, 1'b0, e_none(), "R5");

        // R4 corrupted CRC5
        token(8'h2D, 7'h15, 4'h0, 1'b1, -1, e_none(), "R4");
        data(8'hC3, 1'b0, e_none(), "R4");

        // R1 identifier check failure closes an open transaction
        token(8'h2D, 7'h15, 4'h0, 1'b0, -1, e_tok(4'h0), "R3");
        pk = {};
        pk.push_back(8'h2C);
        send_pkt(pk, 1'b0, -1, e_none(), "R1");
        data(8'hC3, 1'b0, e_none(), "R1");

        // R2 IN token reported but opens nothing
        token(8'h69, 7'h15, 4'h3, 1'b0, -1, e_tok(4'h3), "R2");
        data(8'hC3, 1'b0, e_none(), "R9");

        // R11 short token is corrupt
        token(8'hE1, 7'h15, 4'h1, 1'b0, -1, e_tok(4'h1), "R11");
        pk = {};
        pk.push_back(8'hE1);
        pk.push_back(8'h15);
        send_pkt(pk, 1'b0, -1, e_none(), "R11");
        data(8'hC3, 1'b0, e_none(), "R11");

        // R11 empty packet leaves the open transaction alone
        token(8'h2D, 7'h15, 4'h0, 1'b0, -1, e_tok(4'h0), "R11");
        pk = {};
        send_pkt(pk, 1'b0, -1, e_none(), "R11");
        data(8'hC3, 1'b0, e_ack(4'hD), "R11");

        // R6 address write in the same cycle as the token end uses the old address
        token(8'hE1, 7'h15, 4'h1, 1'b0, 7'h22, e_tok(4'h1), "R6");
        data(8'hC3, 1'b0, e_ack(4'h1), "R7");
        token(8'hE1, 7'h22, 4'h4, 1'b0, -1, e_tok(4'h4), "R6");
        token(8'hE1, 7'h15, 4'h4, 1'b0, -1, e_none(), "R6");

        // R3 field boundaries: top address and endpoint
        write_addr(7'h7F);
        token(8'hE1, 7'h7F, 4'hF, 1'b0, -1, e_tok(4'hF), "R3");
        // R9 a start-of-frame packet closes the transaction
        pk = {};
        pk.push_back(8'hA5);
        pk.push_back(8'h12);
        pk.push_back(8'h34);
        send_pkt(pk, 1'b0, -1, e_none(), "R9");
        data(8'hC3, 1'b0, e_none(), "R9");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errs++;
            $display("FAIL R10: pending results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule